// File: doc/BRIEF.md
# CAS-before-RAS DRAM Refresh Sequencer

This block runs one CAS-before-RAS refresh cycle on a fast-page-mode DRAM each time it is asked. It drives the active-low row and column strobes. It runs from a clock at twice the memory clock, so every strobe edge falls on a half-memory-clock tick. The tick lengths below are all counted in this block clock.

Two 2-bit selectors set the timing. The precharge selector picks between a slow setting (00) and a fast setting (01 or 10). The row-width selector picks one of three strobe-overlap lengths. The value 11 is reserved on both selectors and behaves as 10. The selectors are sampled once, when a request is taken. A `busy` level covers the whole cycle, including the row precharge that follows it, and a one-tick `done` pulse closes the cycle.

Top module: `cbr_refresh_seq`

## Requirements
- R1: After reset, `rasN` and `casN` are high, and `busy` and `done` are low.
- R2: `refReq` sampled high while idle (`busy` low) is accepted. On that same clock edge `casN` falls and `busy` rises.
- R3: `rasN` falls exactly one tick after `casN` falls, so the column strobe always leads.
- R4: The column hold H is the number of ticks from the `rasN` fall to the `casN` rise. With the precharge selector at 00, H is 5, 3 or 1 for row-width 00, 01 or 10. With the precharge selector at 01 or 10, H is 7, 5 or 3 for the same row-width values.
- R5: `rasN` rises one tick after `casN` rises, so `rasN` stays low for H+1 ticks.
- R6: Selector value 11 is timed exactly as 10, on both the precharge selector and the row-width selector.
- R7: After the `rasN` rise, `busy` stays high for P more ticks, where P is 5 for precharge selector 00 and 3 otherwise. `done` is high for exactly the one tick in which `busy` first reads low again.
- R8: A request held high through `done` is accepted on the next edge, so the next `casN` fall comes one tick after the `done` tick. `rasN` is then high for P+2 ticks between cycles, and `casN` is high for at least 4 ticks (precharge selector 00) or 2 ticks (otherwise).
- R9: While `busy` is high, `refReq` and any change to the selectors have no effect: no extra cycle starts, and the running cycle keeps the timing sampled at acceptance.
- R10: `rasN` and `casN` never change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the memory clock rate; one period is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| refReq | input | 1 | Refresh request level |
| preSel | input | 2 | Precharge selector (00 slow, 01/10 fast, 11 as 10) |
| widthSel | input | 2 | Row-width selector (00 longest, 10 shortest, 11 as 10) |
| busy | output | 1 | High from acceptance until the row precharge has elapsed |
| done | output | 1 | One-tick pulse when a refresh cycle completes |
| rasN | output | 1 | Active-low row strobe, registered |
| casN | output | 1 | Active-low column strobe, registered |

## Verification
Two events can fall on the same edge: the completion pulse of one refresh and the acceptance of the next, when the request is held high. The bench holds `refReq` high through a whole cycle. It then checks that the next column fall comes exactly one tick after the `done` tick. It also checks that both strobe high gaps between the two cycles still meet the precharge lengths.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  // Strobes from the sequencing control to the timing datapath.
  typedef struct packed {
    logic latchCfg;   // capture selectors at acceptance
    logic loadHold;   // preload counter with column-hold length
    logic loadPre;    // preload counter with row-precharge length
    logic countDown;  // decrement counter this tick
  } seqCtrlT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HOLD, ST_RREL, ST_PRECH
  } seqStateT;
endpackage

// File: rtl/cbr_refresh_timer.sv
module cbr_refresh_timer
  import cbr_refresh_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int HOLD_LONG  = 5,
  parameter int HOLD_STEP  = 2,
  parameter int FAST_BONUS = 2,
  parameter int PRE_SLOW   = 5,
  parameter int PRE_FAST   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqCtrlT          ctrl,
  input  logic [SEL_W-1:0] preSel,
  input  logic [SEL_W-1:0] widthSel,
  output logic             cntZero
);
  localparam int MAX_HOLD = HOLD_LONG + FAST_BONUS;
  localparam int MAX_LEN  = (MAX_HOLD > PRE_SLOW) ? MAX_HOLD : PRE_SLOW;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);
  localparam logic [SEL_W-1:0] SEL_RSVD = '1;

  logic             cfgFast;
  logic [SEL_W-1:0] cfgWidth;
  logic [SEL_W-1:0] widthEff;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] holdTicks;
  logic [CNT_W-1:0] preTicks;
  int               holdInt;

  // Reserved all-ones code folds onto the next lower code.
  always_comb begin
    widthEff = (widthSel == SEL_RSVD) ? widthSel - 1'b1 : widthSel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgFast  <= 1'b0;
      cfgWidth <= '0;
    end else if (ctrl.latchCfg) begin
      cfgFast  <= (preSel != '0);
      cfgWidth <= widthEff;
    end
  end

  always_comb begin
    holdInt   = HOLD_LONG - HOLD_STEP * int'(cfgWidth) + (cfgFast ? FAST_BONUS : 0);
    holdTicks = CNT_W'(holdInt);
    preTicks  = cfgFast ? CNT_W'(PRE_FAST) : CNT_W'(PRE_SLOW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ctrl.loadHold) begin
      cnt <= holdTicks - 1'b1;
    end else if (ctrl.loadPre) begin
      cnt <= preTicks - 1'b1;
    end else if (ctrl.countDown && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/cbr_refresh_fsm.sv
module cbr_refresh_fsm
  import cbr_refresh_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    refReq,
  input  logic    cntZero,
  output seqCtrlT ctrl,
  output logic    busy,
  output logic    done,
  output logic    rasN,
  output logic    casN
);
  seqStateT state;

  always_comb begin
    ctrl           = '0;
    ctrl.latchCfg  = (state == ST_IDLE) && refReq;
    ctrl.loadHold  = (state == ST_SETUP);
    ctrl.loadPre   = (state == ST_RREL);
    ctrl.countDown = (state == ST_HOLD) || (state == ST_PRECH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rasN  <= 1'b1;
      casN  <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (refReq) begin
          casN  <= 1'b0;
          busy  <= 1'b1;
          state <= ST_SETUP;
        end
        ST_SETUP: begin
          rasN  <= 1'b0;
          state <= ST_HOLD;
        end
        ST_HOLD: if (cntZero) begin
          casN  <= 1'b1;
          state <= ST_RREL;
        end
        ST_RREL: begin
          rasN  <= 1'b1;
          state <= ST_PRECH;
        end
        ST_PRECH: if (cntZero) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq
  import cbr_refresh_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int HOLD_LONG  = 5,
  parameter int HOLD_STEP  = 2,
  parameter int FAST_BONUS = 2,
  parameter int PRE_SLOW   = 5,
  parameter int PRE_FAST   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             refReq,
  input  logic [SEL_W-1:0] preSel,
  input  logic [SEL_W-1:0] widthSel,
  output logic             busy,
  output logic             done,
  output logic             rasN,
  output logic             casN
);
  seqCtrlT ctrl;
  logic    cntZero;

  cbr_refresh_fsm ctrl_i (
    .clk(clk), .rst_n(rst_n), .refReq(refReq), .cntZero(cntZero),
    .ctrl(ctrl), .busy(busy), .done(done), .rasN(rasN), .casN(casN)
  );

  cbr_refresh_timer #(
    .SEL_W(SEL_W), .HOLD_LONG(HOLD_LONG), .HOLD_STEP(HOLD_STEP),
    .FAST_BONUS(FAST_BONUS), .PRE_SLOW(PRE_SLOW), .PRE_FAST(PRE_FAST)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .preSel(preSel),
    .widthSel(widthSel), .cntZero(cntZero)
  );
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic rasN,
  input logic casN
);
  a_r10_no_joint_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !((rasN != $past(rasN)) && (casN != $past(casN))));

  a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> (!casN && !$past(casN) && $past(rasN)));

  a_r2_accept_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(casN) |-> (busy && !$past(busy)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r5_ras_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) |-> (casN && $past(casN) && busy));

  a_r1_strobes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rasN && casN));
endmodule

bind cbr_refresh_seq cbr_refresh_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .rasN(rasN), .casN(casN)
);

// File: tb/cbr_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module cbr_refresh_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refReq = 1'b0;
  logic [1:0] preSel = 2'b00;
  logic [1:0] widthSel = 2'b00;
  logic busy, done, rasN, casN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tCF, tRF, tCR, tRR, tDn;
  int nCasFall = 0;
  int nDone = 0;
  int jointEdges = 0;
  logic pc = 1'b1;
  logic pr = 1'b1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cbr_refresh_seq dut_i (
    .clk(clk), .rst_n(rst_n), .refReq(refReq), .preSel(preSel),
    .widthSel(widthSel), .busy(busy), .done(done), .rasN(rasN), .casN(casN)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Edge recorder, sampled mid-period.
  always @(negedge clk) begin
    if (rst_n) begin
      if (casN !== pc && rasN !== pr) jointEdges++;
      if (pc && !casN) begin tCF = cyc; nCasFall++; end
      if (pr && !rasN) tRF = cyc;
      if (!pc && casN) tCR = cyc;
      if (!pr && rasN) tRR = cyc;
      if (done) begin tDn = cyc; nDone++; end
    end
    pc = casN;
    pr = rasN;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expHold(input logic [1:0] p, input logic [1:0] w);
    int r = (w == 2'b11) ? 2 : int'(w);
    int b = (r == 0) ? 5 : ((r == 1) ? 3 : 1);
    return b + ((p != 2'b00) ? 2 : 0);
  endfunction

  function automatic int expPre(input logic [1:0] p);
    return (p != 2'b00) ? 3 : 5;
  endfunction

  // One refresh with given selectors; checks every edge position.
  task automatic runOne(input logic [1:0] p, input logic [1:0] w, input string tag);
    int acc, n0, h, pp;
    h = expHold(p, w);
    pp = expPre(p);
    @(negedge clk);
    preSel = p; widthSel = w; refReq = 1'b1;
    acc = cyc + 1;
    n0 = nDone;
    @(negedge clk);
    refReq = 1'b0;
    check({tag, " R2 busy after accept"}, int'(busy), 1);
    wait (nDone > n0);
    check({tag, " R2 cas falls at accept"}, tCF, acc);
    check({tag, " R3 ras one tick after cas"}, tRF - tCF, 1);
    check({tag, " R4 column hold"}, tCR - tRF, h);
    check({tag, " R5 ras low ticks"}, tRR - tRF, h + 1);
    check({tag, " R7 precharge busy ticks"}, tDn - tRR, pp);
    @(negedge clk);
    check({tag, " R7 done one tick"}, int'(done), 0);
    check({tag, " R7 busy low after done"}, int'(busy), 0);
  endtask

  task automatic testReset();
    check("R1 rasN reset", int'(rasN), 1);
    check("R1 casN reset", int'(casN), 1);
    check("R1 busy reset", int'(busy), 0);
    check("R1 done reset", int'(done), 0);
  endtask

  task automatic testTable();
    for (int p = 0; p < 3; p++)
      for (int w = 0; w < 3; w++)
        runOne(2'(p), 2'(w), "R4 table");
  endtask

  task automatic testReserved();
    runOne(2'b11, 2'b00, "R6 pre 11");
    runOne(2'b00, 2'b11, "R6 width 11");
    runOne(2'b11, 2'b11, "R6 both 11");
  endtask

  // Request pulses and selector changes during busy have no effect.
  task automatic testIgnore();
    int acc, n0, f0;
    @(negedge clk);
    preSel = 2'b00; widthSel = 2'b00; refReq = 1'b1;
    acc = cyc + 1; n0 = nDone; f0 = nCasFall;
    @(negedge clk);
    refReq = 1'b0;
    repeat (2) @(negedge clk);
    preSel = 2'b01; widthSel = 2'b10; refReq = 1'b1;
    @(negedge clk);
    refReq = 1'b0;
    wait (nDone > n0);
    check("R9 hold unchanged by mid-cycle selectors", tCR - tRF, 5);
    check("R9 precharge unchanged", tDn - tRR, 5);
    check("R9 start edge", tCF, acc);
    repeat (6) @(negedge clk);
    check("R9 no extra cycle from busy request", nCasFall - f0, 1);
    check("R9 casN idle high", int'(casN), 1);
  endtask

  // Held request: completion and next acceptance share an edge.
  task automatic testBackToBack();
    int n0, d1, rr1, cr1;
    @(negedge clk);
    preSel = 2'b00; widthSel = 2'b10; refReq = 1'b1;
    n0 = nDone;
    wait (nDone > n0);
    d1 = tDn; rr1 = tRR; cr1 = tCR;
    wait (nDone > n0 + 1);
    @(negedge clk);
    refReq = 1'b0;
    check("R8 next cas fall after done tick", tCF, d1 + 1);
    check("R8 ras high gap", tRF - rr1, expPre(2'b00) + 2);
    checks++;
    if (tCF - cr1 < 4) begin
      errors++;
      $display("FAIL R8 cas high gap actual %0d expected >= 4", tCF - cr1);
    end
    wait (!busy);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testTable();
    testReserved();
    testIgnore();
    testBackToBack();
    check("R10 strobes never change on one edge", jointEdges, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule